// File: doc/BRIEF.md
# Timer and External Interrupt Flag Register

This block is an 8-bit control and status register on a byte-wide special-function-register bus. It holds the run enables for two timers and the overflow flags for those timers. It also holds a type bit and a detect flag for each of two active-low external interrupt pins. Software reads and writes the register at one fixed bus address. Each timer's overflow pulse sets that timer's flag. Each pin is synchronized, and the pin's type bit decides how the pin raises its flag: on a falling edge or while the pin is low. The four flags leave the block as interrupt request lines. When the vectoring logic outside the block serves a source, it returns a one-cycle acknowledge pulse on the matching line.

Each pin feeds a small state machine that follows its synchronized level. There are two states:

- `PIN_HIGH`: the last synchronized sample was high.
- `PIN_LOW`: the last synchronized sample was low.

There are two transitions:

- `FALL` goes from `PIN_HIGH` to `PIN_LOW`. During that cycle the machine emits a one-cycle falling-edge pulse.
- `RISE` goes from `PIN_LOW` to `PIN_HIGH`.

The reset state is `PIN_HIGH`. The low-level indication used in level mode is taken from the synchronized sample itself.

Top module: `tcr_sfr`

## Requirements
- R1: The register bits, from bit 7 down to bit 0, are: timer1 overflow, timer1 run, timer0 overflow, timer0 run, pin1 detect, pin1 type, pin0 detect, pin0 type. The request line `irq[0]` carries the pin0 detect flag (bit 1), `irq[1]` the timer0 overflow flag (bit 5), `irq[2]` the pin1 detect flag (bit 3), and `irq[3]` the timer1 overflow flag (bit 7). Acknowledge line `vec_ack[k]` belongs to the source on `irq[k]`.
- R2: The register is decoded at bus address 88h. A write with any other address changes nothing. `sfr_rdata` shows the live register value while the address is 88h and 00h otherwise.
- R3: Reset clears the whole register, so all outputs are 0.
- R4: A timer overflow pulse sets that timer's overflow flag at the next rising edge. Its acknowledge clears the flag. A software write can set or clear the flag.
- R5: Only a software write changes a run bit. `tmr_run[i]` equals the run bit of timer i.
- R6: A type bit of 1 selects falling-edge mode for its pin, and 0 selects low-level mode. The mode in force during a cycle is the register's current type bit, so a write that changes the type applies from the following cycle.
- R7: In edge mode, a detected falling edge sets the detect flag, and the pin's acknowledge clears it. A pin that stays low sets the flag again only after it has gone high and then fallen again.
- R8: In level mode, the detect flag follows the pin: it is 1 while the pin is low and 0 while it is high. Acknowledges and software writes have no effect on it.
- R9: Each pin passes through a two-flop synchronizer. A pin change made before one rising edge reaches the detect flag at the third rising edge and not earlier.
- R10: A hardware set of a flag in the same cycle as a software write or an acknowledge wins. A software write wins over a same-cycle acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Bus address |
| sfr_wdata | input | 8 | Bus write data |
| sfr_we | input | 1 | Bus write strobe |
| tmr_ovf | input | 2 | Timer overflow pulses, index = timer |
| ext_int_n | input | 2 | Raw active-low interrupt pins, index = pin |
| vec_ack | input | 4 | Vector acknowledge pulses, same order as irq |
| sfr_rdata | output | 8 | Read data |
| tmr_run | output | 2 | Timer run enables |
| irq | output | 4 | Interrupt requests: pin0, timer0, pin1, timer1 |

## Verification
The bench writes a series of values and chooses the order so that some writes land while a type bit still selects level mode. A design that applied the new type bit in the same cycle would read back detect bits that should have been dropped. It holds a pin low across an acknowledge: a level-triggered detector would set the flag again, while a correct edge detector stays clear. It also counts the exact synchronizer latency, which catches a missing or extra flop. Finally, it collides overflow pulses with clearing writes and acknowledges, where a wrong priority would lose the event.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

    // Synchronized level tracker for one interrupt pin
    typedef enum logic {
        PIN_HIGH = 1'b0,
        PIN_LOW  = 1'b1
    } pin_state_t;

    localparam int unsigned NUM_SRC  = 2;   // timers / pins
    localparam int unsigned REG_W    = 8;

    // bit positions, source i (0 or 1)
    function automatic int unsigned pos_type(input int unsigned i);
        return 2 * i;
    endfunction
    function automatic int unsigned pos_det(input int unsigned i);
        return 2 * i + 1;
    endfunction
    function automatic int unsigned pos_run(input int unsigned i);
        return 2 * i + 4;
    endfunction
    function automatic int unsigned pos_ovf(input int unsigned i);
        return 2 * i + 5;
    endfunction

endpackage

// File: rtl/tcr_pin_sync.sv
module tcr_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;               // idle level of an active-low pin
        end else begin
            chain <= {chain[STAGES-2:0], pin_raw};
        end
    end

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/tcr_pin_fsm.sv
module tcr_pin_fsm
    import tcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    output logic fall_pulse,
    output logic low_level
);
    pin_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_HIGH;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: FALL and RISE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_HIGH: if (!pin_sync) state_d = PIN_LOW;
            PIN_LOW:  if (pin_sync)  state_d = PIN_HIGH;
        endcase
    end

    // outputs
    always_comb begin
        fall_pulse = 1'b0;
        unique case (state_q)
            PIN_HIGH: fall_pulse = !pin_sync;
            PIN_LOW:  fall_pulse = 1'b0;
        endcase
        low_level = !pin_sync;
    end
endmodule

// File: rtl/tcr_flag_cell.sv
module tcr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic level_mode,
    input  logic level_val,
    input  logic hw_set,
    input  logic sw_we,
    input  logic sw_val,
    input  logic ack,
    output logic q
);
    // order: level tracking, hardware set, software write, acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (level_mode) begin
            q <= level_val;
        end else if (hw_set) begin
            q <= 1'b1;
        end else if (sw_we) begin
            q <= sw_val;
        end else if (ack) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/tcr_sfr.sv
module tcr_sfr
    import tcr_pkg::*;
#(
    parameter logic [7:0]  SFR_ADDR    = 8'h88,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_we,
    input  logic [1:0] tmr_ovf,
    input  logic [1:0] ext_int_n,
    input  logic [3:0] vec_ack,
    output logic [7:0] sfr_rdata,
    output logic [1:0] tmr_run,
    output logic [3:0] irq
);
    logic             wr_hit;
    logic [REG_W-1:0] sfr_q;
    logic [1:0]       fall_ev;
    logic [1:0]       lvl_low;
    logic [1:0]       pin_s;

    assign wr_hit = sfr_we && (sfr_addr == SFR_ADDR);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int unsigned PT = pos_type(i);
        localparam int unsigned PD = pos_det(i);
        localparam int unsigned PR = pos_run(i);
        localparam int unsigned PO = pos_ovf(i);

        logic type_q, run_q;

        // external pin path
        tcr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_raw  (ext_int_n[i]),
            .pin_sync (pin_s[i])
        );

        tcr_pin_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_sync   (pin_s[i]),
            .fall_pulse (fall_ev[i]),
            .low_level  (lvl_low[i])
        );

        tcr_flag_cell u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (!type_q),
            .level_val  (lvl_low[i]),
            .hw_set     (fall_ev[i]),
            .sw_we      (wr_hit),
            .sw_val     (sfr_wdata[PD]),
            .ack        (vec_ack[2*i]),
            .q          (sfr_q[PD])
        );

        // timer overflow flag
        tcr_flag_cell u_ovf (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_mode (1'b0),
            .level_val  (1'b0),
            .hw_set     (tmr_ovf[i]),
            .sw_we      (wr_hit),
            .sw_val     (sfr_wdata[PO]),
            .ack        (vec_ack[2*i+1]),
            .q          (sfr_q[PO])
        );

        // software-only bits
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                type_q <= 1'b0;
                run_q  <= 1'b0;
            end else if (wr_hit) begin
                type_q <= sfr_wdata[PT];
                run_q  <= sfr_wdata[PR];
            end
        end

        assign sfr_q[PT]    = type_q;
        assign sfr_q[PR]    = run_q;
        assign tmr_run[i]   = run_q;
        assign irq[2*i]     = sfr_q[PD];
        assign irq[2*i+1]   = sfr_q[PO];
    end

    assign sfr_rdata = (sfr_addr == SFR_ADDR) ? sfr_q : '0;
endmodule

// File: rtl/tcr_sfr_chk.sv
module tcr_sfr_chk
    import tcr_pkg::*;
#(
    parameter logic [7:0] SFR_ADDR = 8'h88
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] sfr_addr,
    input logic       sfr_we,
    input logic [1:0] tmr_ovf,
    input logic [3:0] vec_ack,
    input logic [7:0] sfr_rdata,
    input logic [1:0] tmr_run,
    input logic [7:0] flags,
    input logic [1:0] fall_ev,
    input logic [1:0] lvl_low
);
    logic hit;
    assign hit = sfr_we && (sfr_addr == SFR_ADDR);

    // R3: register held at zero while in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_zero_R3: assert (sfr_rdata == 8'h00 && tmr_run == 2'b00)
                else $error("R3 register not clear in reset");
        end
    end

    // R5: run enables move only on a decoded write
    assert_run_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(tmr_run));

    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R4: overflow sets the flag
        assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf[i] |=> flags[pos_ovf(i)]);

        // R4: acknowledge with no competing event clears
        assert_ovf_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (vec_ack[2*i+1] && !tmr_ovf[i] && !hit) |=> !flags[pos_ovf(i)]);

        // R7: falling edge in edge mode sets the detect flag
        assert_edge_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[pos_type(i)] && fall_ev[i]) |=> flags[pos_det(i)]);

        // R7: acknowledge in edge mode clears when nothing competes
        assert_edge_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[pos_type(i)] && vec_ack[2*i] && !fall_ev[i] && !hit)
            |=> !flags[pos_det(i)]);

        // R8: level mode tracks the synchronized pin
        assert_level_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[pos_type(i)] |=> (flags[pos_det(i)] == $past(lvl_low[i])));
    end
endmodule

bind tcr_sfr tcr_sfr_chk #(.SFR_ADDR(SFR_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_we    (sfr_we),
    .tmr_ovf   (tmr_ovf),
    .vec_ack   (vec_ack),
    .sfr_rdata (sfr_rdata),
    .tmr_run   (tmr_run),
    .flags     (sfr_q),
    .fall_ev   (fall_ev),
    .lvl_low   (lvl_low)
);

// File: tb/tcr_sfr_tb.sv
module tcr_sfr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h88;
    logic [7:0] sfr_wdata = 8'h00;
    logic       sfr_we = 1'b0;
    logic [1:0] tmr_ovf = 2'b00;
    logic [1:0] ext_int_n = 2'b11;
    logic [3:0] vec_ack = 4'h0;
    logic [7:0] sfr_rdata;
    logic [1:0] tmr_run;
    logic [3:0] irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tcr_sfr u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_we    (sfr_we),
        .tmr_ovf   (tmr_ovf),
        .ext_int_n (ext_int_n),
        .vec_ack   (vec_ack),
        .sfr_rdata (sfr_rdata),
        .tmr_run   (tmr_run),
        .irq       (irq)
    );

    // write data and expected readback two cycles later, starting from reset
    localparam int NV = 8;
    localparam logic [7:0] VEC_W [NV] = '{8'hFF, 8'hFF, 8'hA5, 8'h5A, 8'h0A, 8'h33, 8'hCC, 8'h0F};
    localparam logic [7:0] VEC_E [NV] = '{8'hF5, 8'hFF, 8'hA5, 8'h50, 8'h00, 8'h31, 8'hC4, 8'h0D};

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr  = a;
        sfr_wdata = d;
        sfr_we    = 1'b1;
        step(1);
        sfr_we    = 1'b0;
        sfr_addr  = 8'h88;
    endtask

    task automatic pulse_ack(input logic [3:0] a);
        vec_ack = a;
        step(1);
        vec_ack = 4'h0;
    endtask

    initial begin
        step(3);
        // R3 reset state
        check("R3 rdata", sfr_rdata, 8'h00);
        check("R3 irq", {4'h0, irq}, 8'h00);
        check("R3 run", {6'h0, tmr_run}, 8'h00);
        rst_n = 1'b1;
        step(2);

        // table: R6 mode timing, R8 writes ignored in level mode
        for (int k = 0; k < NV; k++) begin
            wr(8'h88, VEC_W[k]);
            step(1);
            check($sformatf("R6/R8 vector %0d", k), sfr_rdata, VEC_E[k]);
        end

        wr(8'h88, 8'h05);
        step(1);
        check("R7 software clear in edge mode", sfr_rdata, 8'h05);

        // R2 address decode
        wr(8'h89, 8'hFF);
        sfr_addr = 8'h89;
        step(1);
        check("R2 other address reads zero", sfr_rdata, 8'h00);
        sfr_addr = 8'h88;
        step(1);
        check("R2 write elsewhere ignored", sfr_rdata, 8'h05);

        // R4 / R1 timer flags
        tmr_ovf = 2'b01; step(1); tmr_ovf = 2'b00;
        check("R4 timer0 set", sfr_rdata, 8'h25);
        check("R1 irq timer0", {4'h0, irq}, 8'h02);
        pulse_ack(4'b0010);
        check("R4 timer0 ack clear", sfr_rdata, 8'h05);
        tmr_ovf = 2'b10; step(1); tmr_ovf = 2'b00;
        check("R1 irq timer1", {4'h0, irq}, 8'h08);
        wr(8'h88, 8'h05);
        check("R4 software clear", sfr_rdata, 8'h05);
        wr(8'h88, 8'h25);
        check("R4 software set", {4'h0, irq}, 8'h02);
        wr(8'h88, 8'h05);

        // R10 priorities
        tmr_ovf = 2'b10; wr(8'h88, 8'h05); tmr_ovf = 2'b00;
        check("R10 overflow beats write", sfr_rdata, 8'h85);
        tmr_ovf = 2'b10; pulse_ack(4'b1000); tmr_ovf = 2'b00;
        check("R10 overflow beats ack", sfr_rdata, 8'h85);
        vec_ack = 4'b0010; wr(8'h88, 8'h25); vec_ack = 4'h0;
        check("R10 write beats ack", sfr_rdata, 8'h25);
        wr(8'h88, 8'h05);

        // R5 run bits
        wr(8'h88, 8'h55);
        check("R5 run enables", {6'h0, tmr_run}, 8'h03);
        pulse_ack(4'hF);
        step(1);
        check("R5 run unaffected by acks", sfr_rdata, 8'h55);
        wr(8'h88, 8'h05);

        // R7 / R9 edge mode on pin0
        ext_int_n[0] = 1'b0;
        step(2);
        check("R9 no flag before third edge", {4'h0, irq}, 8'h00);
        step(1);
        check("R7 falling edge sets", sfr_rdata, 8'h07);
        check("R1 irq pin0", {4'h0, irq}, 8'h01);
        pulse_ack(4'b0001);
        check("R7 ack clears", {4'h0, irq}, 8'h00);
        step(4);
        check("R7 held low no retrigger", {4'h0, irq}, 8'h00);
        ext_int_n[0] = 1'b1; step(4);
        ext_int_n[0] = 1'b0; step(3);
        check("R7 second edge sets", {4'h0, irq}, 8'h01);
        pulse_ack(4'b0001);
        ext_int_n[0] = 1'b1; step(4);

        // R8 / R9 level mode on pin1
        wr(8'h88, 8'h00);
        ext_int_n[1] = 1'b0;
        step(3);
        check("R8 level low sets", sfr_rdata, 8'h08);
        check("R1 irq pin1", {4'h0, irq}, 8'h04);
        pulse_ack(4'b0100);
        check("R8 ack ignored", sfr_rdata, 8'h08);
        wr(8'h88, 8'h00);
        check("R8 write ignored", sfr_rdata, 8'h08);
        ext_int_n[1] = 1'b1;
        step(2);
        check("R9 release latency", sfr_rdata, 8'h08);
        step(1);
        check("R8 level high clears", sfr_rdata, 8'h00);

        // R6 switch pin0 from level to edge while low
        ext_int_n[0] = 1'b0;
        step(3);
        check("R6 level flag", sfr_rdata, 8'h02);
        wr(8'h88, 8'h01);
        step(2);
        check("R6 flag kept after switch", sfr_rdata, 8'h03);
        pulse_ack(4'b0001);
        check("R6 edge mode ack clears", sfr_rdata, 8'h01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule